// File: doc/BRIEF.md
# Four-Lane Single-Precision Compare with Mask Output

This block compares two packed vectors of 32-bit IEEE-754 binary values, one lane at a time. For each lane it writes an all-ones or all-zeros mask into the result. It also forms a 2-bit condition code that says whether all, some or none of the evaluated lanes matched. The relation can be equality, greater-than or greater-or-equal. The block takes raw bit patterns and classifies NaNs, signaling NaNs and zeros itself.

Each lane raises an invalid flag, which goes to an external exception encoder. In signaling mode any NaN operand raises the flag. In quiet mode only a signaling NaN raises it. A stop control models trapping invalid operations: the first lane that raises invalid is still written, and every lane above it is left unevaluated. In single-element mode only lane 0 takes part. The result arrives on registered outputs one clock after the request.

Top module: `fpcmp_vec`

## Requirements
- R1: Lane i of the result occupies bits [32i+31:32i] and is either all ones (relation holds) or all zeros.
- R2: The condition code is 0 when every evaluated lane matched and all lanes were evaluated, 1 when at least one lane matched but not that case, and 3 when no lane matched; the value 2 never appears.
- R3: With single-element mode set, only lane 0 is evaluated: a match gives condition code 0, no match gives 3, and lanes 1 to 3 carry a zero mask and no invalid flag.
- R4: The relation code selects the test: 0 gives first equals second, 1 gives first greater than second (computed as second less than first), 2 gives first greater-or-equal to second (computed as second less-or-equal to first), and 3 never matches.
- R5: Any comparison with a NaN operand is false, and positive zero equals negative zero.
- R6: Non-NaN values are ordered by sign and magnitude, so negative values order below positive ones, a larger magnitude orders lower among negatives, and infinities and subnormals take part like any other value.
- R7: With the signaling control set, a lane with any NaN operand raises its invalid flag. With it clear, only a signaling NaN raises the flag. A signaling NaN has an all-ones exponent, a nonzero fraction and fraction bit 22 clear.
- R8: With the stop control set, the lowest lane that raises invalid is still evaluated, but every higher lane gives a zero mask and no flag, and the condition code counts only the evaluated lanes.
- R9: Results appear one clock after a request is accepted. A synchronous active-high reset clears the valid output, the mask, the flags and the condition code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_single | input | 1 | Single-element mode (lane 0 only) |
| in_signaling | input | 1 | 1: any NaN raises invalid; 0: only signaling NaNs raise it |
| in_stop_on_inv | input | 1 | Stop evaluating lanes above the first invalid lane |
| in_rel | input | 2 | Relation: 0 equal, 1 greater, 2 greater-or-equal, 3 none |
| in_a | input | 128 | First operand vector, lane 0 in the low bits |
| in_b | input | 128 | Second operand vector, lane 0 in the low bits |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_mask | output | 128 | Per-lane all-ones or all-zeros mask |
| out_cc | output | 2 | Condition code 0, 1 or 3 |
| out_inv | output | 4 | Per-lane invalid flags |

## Verification
On every cycle the assertions check the following. Each lane mask is solid. The condition code is never 2 and agrees with an empty or a full mask. Single-element requests leave the upper lanes and flags clear. A stopped request has no flags or mask bits above its flagged lane and at most one flag. The valid output follows the request by one cycle. Only the bench's scenarios can show that the numeric ordering is right: signed zeros, infinities, subnormals and negative magnitudes. They also show that each relation code selects the right test and that quiet and signaling NaNs are told apart in each mode.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int FP_EXP_W  = 8;
  localparam int FP_FRAC_W = 23;
  localparam int FP_W      = 1 + FP_EXP_W + FP_FRAC_W;

  typedef enum logic [1:0] {
    REL_EQ   = 2'd0,
    REL_GT   = 2'd1,
    REL_GE   = 2'd2,
    REL_NONE = 2'd3
  } rel_e;

  localparam logic [1:0] CC_ALL  = 2'd0;
  localparam logic [1:0] CC_SOME = 2'd1;
  localparam logic [1:0] CC_NONE = 2'd3;

  typedef struct packed {
    logic hit;
    logic inv;
  } lane_res_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] bits,
  output logic         is_nan,
  output logic         is_snan,
  output logic         is_zero,
  output logic         sign,
  output logic [W-2:0] mag
);
  logic exp_ones;
  logic frac_nz;

  always_comb begin
    exp_ones = &bits[W-2:FRAC_W];
    frac_nz  = |bits[FRAC_W-1:0];
    sign     = bits[W-1];
    mag      = bits[W-2:0];
    is_nan   = exp_ones && frac_nz;
    // R7: quiet bit is the top fraction bit
    is_snan  = is_nan && !bits[FRAC_W-1];
    is_zero  = !(|bits[W-2:0]);
  end
endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  rel_e         rel,
  input  logic         signaling,
  output lane_res_t    res
);
  logic         a_nan, a_snan, a_zero, a_sign;
  logic         b_nan, b_snan, b_zero, b_sign;
  logic [W-2:0] a_mag, b_mag;

  fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .bits(op_a), .is_nan(a_nan), .is_snan(a_snan), .is_zero(a_zero),
    .sign(a_sign), .mag(a_mag)
  );
  fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .bits(op_b), .is_nan(b_nan), .is_snan(b_snan), .is_zero(b_zero),
    .sign(b_sign), .mag(b_mag)
  );

  logic unordered, both_zero, eq_ab, lt_ba, le_ba;

  always_comb begin
    unordered = a_nan || b_nan;                       // R5
    both_zero = a_zero && b_zero;                     // R5
    eq_ab     = !unordered && (both_zero || (op_a == op_b));
    // R6: second operand below first, sign-magnitude order
    lt_ba     = !unordered && !both_zero &&
                ((b_sign && !a_sign) ||
                 (!b_sign && !a_sign && (b_mag < a_mag)) ||
                 (b_sign && a_sign && (b_mag > a_mag)));
    le_ba     = lt_ba || eq_ab;

    unique case (rel)                                 // R4
      REL_EQ:  res.hit = eq_ab;
      REL_GT:  res.hit = lt_ba;
      REL_GE:  res.hit = le_ba;
      default: res.hit = 1'b0;
    endcase
    res.inv = signaling ? unordered : (a_snan || b_snan);  // R7
  end
endmodule

// File: rtl/fpcmp_vec.sv
module fpcmp_vec
  import fpcmp_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int VW    = LANES * W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_single,
  input  logic             in_signaling,
  input  logic             in_stop_on_inv,
  input  logic [1:0]       in_rel,
  input  logic [VW-1:0]    in_a,
  input  logic [VW-1:0]    in_b,
  output logic             out_valid,
  output logic [VW-1:0]    out_mask,
  output logic [1:0]       out_cc,
  output logic [LANES-1:0] out_inv
);
  lane_res_t        lane_res [LANES];
  logic [LANES:0]   alive;
  logic [LANES-1:0] hit_act, inv_act;
  logic [VW-1:0]    mask_d;
  logic [1:0]       cc_d;
  logic             all_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fpcmp_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lane (
      .op_a     (in_a[g*W +: W]),
      .op_b     (in_b[g*W +: W]),
      .rel      (rel_e'(in_rel)),
      .signaling(in_signaling),
      .res      (lane_res[g])
    );

    // R3, R8: a lane is evaluated only while every lower lane let it through
    if (g == 0) begin : g_first
      assign alive[1] = !in_single &&
                        !(in_stop_on_inv && lane_res[0].inv);
    end else begin : g_rest
      assign alive[g+1] = alive[g] &&
                          !(in_stop_on_inv && lane_res[g].inv);
    end

    assign hit_act[g]       = alive[g] && lane_res[g].hit;
    assign inv_act[g]       = alive[g] && lane_res[g].inv;
    assign mask_d[g*W +: W] = {W{hit_act[g]}};        // R1
  end
  assign alive[0] = 1'b1;

  always_comb begin
    all_hit = in_single ? hit_act[0] : (&hit_act);    // R2, R3
    if (all_hit)           cc_d = CC_ALL;
    else if (|hit_act)     cc_d = CC_SOME;
    else                   cc_d = CC_NONE;
  end

  always_ff @(posedge clk) begin                      // R9
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_cc    <= CC_ALL;
      out_inv   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mask <= mask_d;
        out_cc   <= cc_d;
        out_inv  <= inv_act;
      end
    end
  end
endmodule

// File: rtl/fpcmp_vec_chk.sv
module fpcmp_vec_chk #(
  parameter int LANES = 4,
  parameter int W     = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_single,
  input logic             in_stop_on_inv,
  input logic             out_valid,
  input logic [LANES*W-1:0] out_mask,
  input logic [1:0]       out_cc,
  input logic [LANES-1:0] out_inv
);
  for (genvar g = 0; g < LANES; g++) begin : g_solid
    AST_LANE_SOLID: assert property (@(posedge clk) disable iff (rst)
      (&out_mask[g*W +: W]) || !(|out_mask[g*W +: W]));  // R1
  end

  for (genvar g = 0; g < LANES - 1; g++) begin : g_stop
    AST_STOP_CLEARS_ABOVE: assert property (@(posedge clk) disable iff (rst)
      out_valid && $past(in_stop_on_inv) && out_inv[g] |->
        (out_mask[LANES*W-1:(g+1)*W] == '0) && (out_inv[LANES-1:g+1] == '0));  // R8
  end

  AST_STOP_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(in_stop_on_inv) |-> $onehot0(out_inv));  // R8

  AST_CC_NEVER_TWO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_cc != 2'd2);  // R2

  AST_CC_EMPTY_NONE: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_mask == '0) |-> out_cc == 2'd3);  // R2

  AST_CC_FULL_ALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && (&out_mask) |-> out_cc == 2'd0);  // R2

  AST_SINGLE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_single |=>
      (out_mask[LANES*W-1:W] == '0) && (out_inv[LANES-1:1] == '0));  // R3

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R9

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);  // R9
endmodule

bind fpcmp_vec fpcmp_vec_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_single     (in_single),
  .in_stop_on_inv(in_stop_on_inv),
  .out_valid     (out_valid),
  .out_mask      (out_mask),
  .out_cc        (out_cc),
  .out_inv       (out_inv)
);

// File: tb/test_fpcmp_vec.sv
module test_fpcmp_vec;
  localparam int LANES = 4;
  localparam int W     = 32;
  localparam int VW    = LANES * W;

  localparam logic [31:0] ONE = 32'h3F800000, TWO = 32'h40000000,
                          THR = 32'h40400000, M1  = 32'hBF800000,
                          M2  = 32'hC0000000, PZ  = 32'h00000000,
                          NZ  = 32'h80000000, QN  = 32'h7FC00000,
                          SN  = 32'h7F800001, PI  = 32'h7F800000,
                          NI  = 32'hFF800000;

  typedef struct packed {
    logic [VW-1:0] a;
    logic [VW-1:0] b;
    logic [1:0]    rel;
    logic          single;
    logic          sig;
    logic          stop;
    logic [3:0]    m;
    logic [1:0]    cc;
    logic [3:0]    inv;
    logic [63:0]   tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{{ONE,TWO,M1,PZ}, {ONE,THR,M1,NZ}, 2'd0, 1'b0,1'b0,1'b0, 4'b1011, 2'd1, 4'b0000, "R4 R5"},
    '{{TWO,M1,PI,ONE}, {ONE,M2,PI,NI},  2'd1, 1'b0,1'b0,1'b0, 4'b1101, 2'd1, 4'b0000, "R4 R6"},
    '{{TWO,M1,PI,ONE}, {ONE,M2,PI,NI},  2'd2, 1'b0,1'b0,1'b0, 4'b1111, 2'd0, 4'b0000, "R2 R4"},
    '{{M2,M1,PZ,NZ},   {M1,ONE,NZ,PZ},  2'd1, 1'b0,1'b0,1'b0, 4'b0000, 2'd3, 4'b0000, "R5 R6"},
    '{{QN,SN,ONE,ONE}, {QN,ONE,ONE,TWO},2'd0, 1'b0,1'b0,1'b0, 4'b0010, 2'd1, 4'b0100, "R7"},
    '{{QN,SN,ONE,ONE}, {QN,ONE,ONE,TWO},2'd0, 1'b0,1'b1,1'b0, 4'b0010, 2'd1, 4'b1100, "R7"},
    '{{QN,SN,ONE,ONE}, {QN,ONE,ONE,TWO},2'd0, 1'b0,1'b1,1'b1, 4'b0010, 2'd1, 4'b0100, "R8"},
    '{{ONE,ONE,ONE,QN},{ONE,ONE,ONE,ONE},2'd0,1'b0,1'b1,1'b1, 4'b0000, 2'd3, 4'b0001, "R8"},
    '{{ONE,ONE,ONE,ONE},{ONE,ONE,ONE,ONE},2'd0,1'b1,1'b0,1'b0,4'b0001, 2'd0, 4'b0000, "R3"},
    '{{ONE,ONE,ONE,TWO},{ONE,ONE,ONE,ONE},2'd0,1'b1,1'b0,1'b0,4'b0000, 2'd3, 4'b0000, "R3"},
    '{{QN,QN,QN,TWO},  {ONE,ONE,ONE,ONE},2'd1,1'b1,1'b1,1'b0, 4'b0001, 2'd0, 4'b0000, "R3 R7"},
    '{{ONE,ONE,ONE,ONE},{ONE,ONE,ONE,ONE},2'd3,1'b0,1'b0,1'b0,4'b0000, 2'd3, 4'b0000, "R4"},
    '{{32'h7F7FFFFF,32'hFF7FFFFF,32'h00000001,32'h3F800001}, {PI,NI,PZ,ONE},
      2'd1, 1'b0,1'b0,1'b0, 4'b0111, 2'd1, 4'b0000, "R6"},
    '{{QN,ONE,ONE,ONE},{ONE,ONE,ONE,ONE},2'd0,1'b0,1'b0,1'b1, 4'b0111, 2'd1, 4'b0000, "R8"},
    '{{ONE,ONE,SN,ONE},{ONE,ONE,ONE,ONE},2'd0,1'b0,1'b0,1'b1, 4'b0001, 2'd1, 4'b0010, "R8"}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_single = 1'b0;
  logic             in_signaling = 1'b0;
  logic             in_stop_on_inv = 1'b0;
  logic [1:0]       in_rel = 2'd0;
  logic [VW-1:0]    in_a = '0;
  logic [VW-1:0]    in_b = '0;
  logic             out_valid;
  logic [VW-1:0]    out_mask;
  logic [1:0]       out_cc;
  logic [LANES-1:0] out_inv;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fpcmp_vec i_fpcmp_vec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_single(in_single),
    .in_signaling(in_signaling), .in_stop_on_inv(in_stop_on_inv),
    .in_rel(in_rel), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_mask(out_mask), .out_cc(out_cc), .out_inv(out_inv)
  );

  task automatic chk(input string what, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] expand(input logic [3:0] m);
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*W +: W] = {W{m[i]}};
    return r;
  endfunction

  task automatic apply(input vec_t v);
    @(negedge clk);
    in_valid       = 1'b1;
    in_a           = v.a;
    in_b           = v.b;
    in_rel         = v.rel;
    in_single      = v.single;
    in_signaling   = v.sig;
    in_stop_on_inv = v.stop;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset valid", VW'(out_valid), '0);
    chk("R9 reset mask", out_mask, '0);
    chk("R9 reset cc", VW'(out_cc), '0);
    chk("R9 reset inv", VW'(out_inv), '0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k]);
      chk($sformatf("%s R9 vec%0d valid", VECS[k].tag, k), VW'(out_valid), VW'(1));
      chk($sformatf("%s R1 vec%0d mask", VECS[k].tag, k), out_mask, expand(VECS[k].m));
      chk($sformatf("%s R2 vec%0d cc", VECS[k].tag, k), VW'(out_cc), VW'(VECS[k].cc));
      chk($sformatf("%s vec%0d inv", VECS[k].tag, k), VW'(out_inv), VW'(VECS[k].inv));
    end

    // R9: valid drops one cycle after the strobe is released
    @(negedge clk);
    chk("R9 valid idle", VW'(out_valid), '0);

    // R9: reset in mid-run clears outputs again
    apply(VECS[2]);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 re-reset mask", out_mask, '0);
    chk("R9 re-reset cc", VW'(out_cc), '0);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fail++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
      wait (done);
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule